// File: doc/BRIEF.md
# PLL Phase-Step Sequencer

This block sits in the core logic next to a PLL and drives its dynamic phase-adjust port. A user asks for a number of phase steps, a direction and a target counter in one request cycle. The sequencer then performs the steps one at a time. For each step it drives the direction and counter-select lines, pulses the step strobe for a fixed number of cycles, and waits until the PLL reports that the adjustment has finished. Only then does it begin the next step.

Everything runs on the free-running scan clock. The PLL's completion flag is timed by the PLL itself, so the block passes it through a resynchroniser. It accepts completion only after it has seen that flag low following the start of the strobe, so a level still high from the previous step is never taken as an acknowledgment. A programmable timeout ends a step that never completes. Any select code the PLL does not define is refused before any activity starts.

Top module: `phstep_seq`

## Requirements
- R1: `phase_up` and `phase_sel` carry the requested values for at least one full cycle before `phase_step` rises.
- R2: For each phase step, `phase_step` stays high for exactly STROBE_CYC consecutive cycles (default 2; any value below 2 is refused at elaboration).
- R3: The number of `phase_step` pulses equals `req_steps`. A request of zero steps produces no pulse and a single `seq_done` pulse.
- R4: A new pulse starts only after the resynchronised `pll_done` has been seen low after the previous pulse began and then high again. A `pll_done` stuck high therefore never completes a step, and the step ends in a timeout.
- R5: `phase_up` and `phase_sel` stay constant for the entire time `busy` is high.
- R6: Select encoding: 4'd0 addresses all output counters, 4'd1 to 4'd10 address output counters 0 to 9, and 4'd11 addresses the feedback counter. A request carrying any of the codes 4'd12 to 4'd15 gives a one-cycle `err_bad_sel` pulse with no strobe, and `busy` stays low.
- R7: If completion is not seen within `req_timeout` cycles of the done-wait, `err_timeout` pulses for one cycle, `busy` falls, and the remaining steps are dropped.
- R8: A request is accepted only while `busy` is low. `req_valid` while busy has no effect on the pulse count or the outputs.
- R9: After the last step completes, `seq_done` is high for exactly one cycle, and `busy` is low in that same cycle.
- R10: After reset, `phase_step`, `busy`, `seq_done`, both error flags, `phase_up` and `phase_sel` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running scan clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_steps | input | CNT_W | Number of phase steps requested |
| req_up | input | 1 | Direction: 1 steps up, 0 steps down |
| req_sel | input | 4 | Target counter code |
| req_timeout | input | TO_W | Done-wait limit in cycles, at least 1 |
| pll_done | input | 1 | PLL adjustment-complete flag, asynchronous timing |
| phase_step | output | 1 | Step strobe to the PLL |
| phase_up | output | 1 | Direction to the PLL |
| phase_sel | output | 4 | Counter select to the PLL |
| busy | output | 1 | A sequence is in progress |
| seq_done | output | 1 | One-cycle pulse when all steps have completed |
| err_bad_sel | output | 1 | One-cycle pulse when a select code is refused |
| err_timeout | output | 1 | One-cycle pulse when a done-wait is aborted |

## Verification
The checker assumes that `pll_done` acts like a PLL: it drops after a strobe begins and rises some cycles after the strobe ends, or it stays stuck in a fault scenario. It also assumes that a request's fields are stable during the cycle `req_valid` is high. The bench's PLL model lowers the flag while the strobe is high and raises it after a programmed delay. Two fault modes hold the flag low forever or high forever. Requests are driven for exactly one cycle, and the timeout is set comfortably above the model delay except in the timeout scenarios.

// File: rtl/phstep_pkg.sv
package phstep_pkg;
   localparam int SEL_W = 4;
   localparam logic [SEL_W-1:0] SEL_ALL_OUT = 4'd0;
   localparam logic [SEL_W-1:0] SEL_FBK     = 4'd11;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_STROBE = 2'd2,
      ST_WAIT   = 2'd3
   } phs_state_e;

   function automatic logic sel_legal(input logic [SEL_W-1:0] code);
      return code <= SEL_FBK;
   endfunction
endpackage

// File: rtl/phstep_sync.sv
module phstep_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else if (STAGES == 1) begin : g_one
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= d_in;
         end
         assign d_out = q;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2:0], d_in};
         end
         assign d_out = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/phstep_timer.sv
module phstep_timer #(
   parameter int TO_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [TO_W-1:0] limit,
   output logic            expired
);
   logic [TO_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (run) cnt <= cnt + 1'b1;
      else          cnt <= '0;
   end

   assign expired = run && (({1'b0, cnt} + 1'b1) >= {1'b0, limit});
endmodule

// File: rtl/phstep_ctrl.sv
module phstep_ctrl
   import phstep_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int TO_W       = 16,
   parameter int STROBE_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [CNT_W-1:0] req_steps,
   input  logic             req_up,
   input  logic [SEL_W-1:0] req_sel,
   input  logic [TO_W-1:0]  req_timeout,
   input  logic             done_s,
   input  logic             tmo,
   output logic             timer_run,
   output logic [TO_W-1:0]  timer_lim,
   output logic             phase_step,
   output logic             phase_up,
   output logic [SEL_W-1:0] phase_sel,
   output logic             busy,
   output logic             seq_done,
   output logic             err_bad_sel,
   output logic             err_timeout
);
   localparam int SW = $clog2(STROBE_CYC);

   phs_state_e       state;
   logic [CNT_W-1:0] remain;
   logic [SW-1:0]    scnt;
   logic             armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         remain      <= '0;
         scnt        <= '0;
         armed       <= 1'b0;
         phase_up    <= 1'b0;
         phase_sel   <= '0;
         timer_lim   <= '0;
         seq_done    <= 1'b0;
         err_bad_sel <= 1'b0;
         err_timeout <= 1'b0;
      end else begin
         seq_done    <= 1'b0;
         err_bad_sel <= 1'b0;
         err_timeout <= 1'b0;
         case (state)
            ST_IDLE: begin
               armed <= 1'b0;
               if (req_valid) begin
                  if (!sel_legal(req_sel)) begin
                     err_bad_sel <= 1'b1;
                  end else if (req_steps == '0) begin
                     seq_done <= 1'b1;
                  end else begin
                     phase_up  <= req_up;
                     phase_sel <= req_sel;
                     remain    <= req_steps;
                     timer_lim <= req_timeout;
                     state     <= ST_SETUP;
                  end
               end
            end
            ST_SETUP: begin
               scnt  <= '0;
               armed <= 1'b0;
               state <= ST_STROBE;
            end
            ST_STROBE: begin
               if (!done_s) armed <= 1'b1;
               if (scnt == SW'(STROBE_CYC - 1)) state <= ST_WAIT;
               else                             scnt  <= scnt + 1'b1;
            end
            ST_WAIT: begin
               if (!done_s) armed <= 1'b1;
               if (armed && done_s) begin
                  if (remain == CNT_W'(1)) begin
                     seq_done <= 1'b1;
                     state    <= ST_IDLE;
                  end else begin
                     remain <= remain - 1'b1;
                     state  <= ST_SETUP;
                  end
               end else if (tmo) begin
                  err_timeout <= 1'b1;
                  state       <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign phase_step = (state == ST_STROBE);
   assign timer_run  = (state == ST_WAIT);
   assign busy       = (state != ST_IDLE);
endmodule

// File: rtl/phstep_seq.sv
module phstep_seq
   import phstep_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int TO_W        = 16,
   parameter int STROBE_CYC  = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [CNT_W-1:0] req_steps,
   input  logic             req_up,
   input  logic [3:0]       req_sel,
   input  logic [TO_W-1:0]  req_timeout,
   input  logic             pll_done,
   output logic             phase_step,
   output logic             phase_up,
   output logic [3:0]       phase_sel,
   output logic             busy,
   output logic             seq_done,
   output logic             err_bad_sel,
   output logic             err_timeout
);
   generate
      if (STROBE_CYC < 2) begin : g_bad_strobe
         $error("phstep_seq: STROBE_CYC must be 2 or more");
      end
      if (CNT_W < 1 || TO_W < 2) begin : g_bad_width
         $error("phstep_seq: CNT_W or TO_W too small");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("phstep_seq: SYNC_STAGES out of range 0..4");
      end
   endgenerate

   logic            done_s;
   logic            tmo;
   logic            timer_run;
   logic [TO_W-1:0] timer_lim;

   phstep_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pll_done),
      .d_out (done_s)
   );

   phstep_timer #(.TO_W(TO_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (timer_run),
      .limit   (timer_lim),
      .expired (tmo)
   );

   phstep_ctrl #(
      .CNT_W      (CNT_W),
      .TO_W       (TO_W),
      .STROBE_CYC (STROBE_CYC)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_steps   (req_steps),
      .req_up      (req_up),
      .req_sel     (req_sel),
      .req_timeout (req_timeout),
      .done_s      (done_s),
      .tmo         (tmo),
      .timer_run   (timer_run),
      .timer_lim   (timer_lim),
      .phase_step  (phase_step),
      .phase_up    (phase_up),
      .phase_sel   (phase_sel),
      .busy        (busy),
      .seq_done    (seq_done),
      .err_bad_sel (err_bad_sel),
      .err_timeout (err_timeout)
   );
endmodule

// File: rtl/phstep_seq_chk.sv
module phstep_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       phase_step,
   input logic       phase_up,
   input logic [3:0] phase_sel,
   input logic       busy,
   input logic       seq_done,
   input logic       err_bad_sel,
   input logic       err_timeout
);
   AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase_step) |-> $stable(phase_up) && $stable(phase_sel)); // R1
   AST_STROBE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(phase_step) |-> $past(phase_step, 2)); // R2
   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(phase_up) && $stable(phase_sel)); // R5
   AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> phase_sel <= 4'd11); // R6
   AST_BADSEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_bad_sel |-> !busy && !phase_step); // R6
   AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      err_timeout |-> !busy); // R7
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done); // R9
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> !busy && !err_timeout && !err_bad_sel); // R9
   AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !phase_step); // R3
endmodule

bind phstep_seq phstep_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .phase_step  (phase_step),
   .phase_up    (phase_up),
   .phase_sel   (phase_sel),
   .busy        (busy),
   .seq_done    (seq_done),
   .err_bad_sel (err_bad_sel),
   .err_timeout (err_timeout)
);

// File: tb/phstep_seq_tb.sv
`timescale 1ns/1ps
module phstep_seq_tb;
   localparam int CNT_W = 8;
   localparam int TO_W  = 16;
   localparam int SCYC  = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [CNT_W-1:0] req_steps = '0;
   logic             req_up = 1'b0;
   logic [3:0]       req_sel = '0;
   logic [TO_W-1:0]  req_timeout = '0;
   logic             pll_done = 1'b1;
   logic             phase_step, phase_up, busy, seq_done, err_bad_sel, err_timeout;
   logic [3:0]       phase_sel;

   always #2 clk = ~clk;

   phstep_seq #(.CNT_W(CNT_W), .TO_W(TO_W), .STROBE_CYC(SCYC), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_steps(req_steps),
      .req_up(req_up), .req_sel(req_sel), .req_timeout(req_timeout),
      .pll_done(pll_done), .phase_step(phase_step), .phase_up(phase_up),
      .phase_sel(phase_sel), .busy(busy), .seq_done(seq_done),
      .err_bad_sel(err_bad_sel), .err_timeout(err_timeout)
   );

   int checks = 0;
   int errors = 0;

   // monitor and PLL model state
   int   pll_mode = 0;   // 0 normal, 1 never rises, 2 stuck high
   int   pll_dly  = 4;
   int   pll_cnt  = 0;
   bit   ack = 1'b1;
   bit   step_prev = 1'b0, done_prev = 1'b0;
   bit   prev_up = 1'b0;
   logic [3:0] prev_sel = '0;
   bit   exp_up = 1'b0;
   logic [3:0] exp_sel = '0;
   int   width = 0, strobes = 0, width_err = 0, setup_err = 0, hold_err = 0;
   int   r4_err = 0, done_cnt = 0, done_w_err = 0, badsel_cnt = 0, tmo_cnt = 0;
   int   busy_seen = 0;

   always @(negedge clk) begin
      if (phase_step && !step_prev) begin
         strobes++;
         if (phase_up != exp_up || phase_sel != exp_sel ||
             prev_up != exp_up || prev_sel != exp_sel) setup_err++;
         if (!ack) r4_err++;
         ack = 1'b0;
         width = 1;
      end else if (phase_step) begin
         width++;
      end
      if (!phase_step && step_prev && width != SCYC) width_err++;
      if (busy) begin
         busy_seen++;
         if (phase_up != exp_up || phase_sel != exp_sel) hold_err++;
      end
      if (seq_done) begin
         done_cnt++;
         if (done_prev || busy) done_w_err++;
      end
      if (err_bad_sel) badsel_cnt++;
      if (err_timeout) tmo_cnt++;
      step_prev = phase_step;
      done_prev = seq_done;
      prev_up   = phase_up;
      prev_sel  = phase_sel;
      // PLL model
      if (pll_mode == 2) begin
         pll_done = 1'b1;
      end else if (phase_step) begin
         pll_done = 1'b0;
         pll_cnt  = 0;
      end else if (!pll_done && pll_mode == 0) begin
         pll_cnt++;
         if (pll_cnt >= pll_dly) begin
            pll_done = 1'b1;
            ack = 1'b1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clear_mon();
      strobes = 0; width_err = 0; setup_err = 0; hold_err = 0; r4_err = 0;
      done_cnt = 0; done_w_err = 0; badsel_cnt = 0; tmo_cnt = 0; busy_seen = 0;
   endtask

   task automatic issue(input int n, input bit up, input logic [3:0] sel, input int lim);
      req_valid = 1'b1; req_steps = CNT_W'(n); req_up = up; req_sel = sel;
      req_timeout = TO_W'(lim);
      tick(1);
      req_valid = 1'b0;
   endtask

   task automatic wait_end();
      for (int i = 0; i < 5000; i++) begin
         if (done_cnt > 0 || tmo_cnt > 0 || badsel_cnt > 0) break;
         tick(1);
      end
      tick(3);
   endtask

   task automatic t_reset();
      chk(!phase_step && !busy && !seq_done && !err_bad_sel && !err_timeout,
          "R10 control outputs", int'({phase_step, busy, seq_done, err_bad_sel, err_timeout}), 0);
      chk(!phase_up && phase_sel == 4'd0, "R10 direction/select", int'({phase_up, phase_sel}), 0);
   endtask

   task automatic t_run(input int n, input bit up, input logic [3:0] sel, input int dly);
      clear_mon();
      pll_mode = 0; pll_dly = dly; exp_up = up; exp_sel = sel;
      issue(n, up, sel, dly + 20);
      wait_end();
      chk(strobes == n, "R3 pulse count", strobes, n);
      chk(width_err == 0, "R2 strobe width", width_err, 0);
      chk(setup_err == 0, "R1 setup before strobe", setup_err, 0);
      chk(hold_err == 0, "R5 hold while busy", hold_err, 0);
      chk(r4_err == 0, "R4 strobe after done", r4_err, 0);
      chk(done_cnt == 1 && done_w_err == 0, "R9 single done pulse", done_cnt, 1);
      chk(tmo_cnt == 0 && !busy, "R9 idle after done", tmo_cnt + int'(busy), 0);
   endtask

   task automatic t_zero();
      clear_mon();
      issue(0, 1'b1, 4'd3, 30);
      wait_end();
      chk(strobes == 0, "R3 zero steps no pulse", strobes, 0);
      chk(done_cnt == 1 && busy_seen == 0, "R3 zero steps completes", done_cnt, 1);
   endtask

   task automatic t_badsel(input logic [3:0] sel);
      clear_mon();
      issue(3, 1'b1, sel, 30);
      wait_end();
      chk(badsel_cnt == 1, "R6 bad select flagged", badsel_cnt, 1);
      chk(strobes == 0 && busy_seen == 0, "R6 bad select no action", strobes + busy_seen, 0);
   endtask

   task automatic t_timeout();
      clear_mon();
      pll_mode = 1; exp_up = 1'b0; exp_sel = 4'd4;
      issue(4, 1'b0, 4'd4, 10);
      wait_end();
      chk(tmo_cnt == 1, "R7 timeout flagged", tmo_cnt, 1);
      chk(strobes == 1 && done_cnt == 0, "R7 remaining steps dropped", strobes, 1);
      chk(!busy, "R7 idle after timeout", int'(busy), 0);
      pll_mode = 0; pll_done = 1'b1; ack = 1'b1;
      tick(4);
   endtask

   task automatic t_stale();
      clear_mon();
      pll_mode = 2; exp_up = 1'b1; exp_sel = 4'd7;
      issue(2, 1'b1, 4'd7, 12);
      wait_end();
      chk(tmo_cnt == 1 && done_cnt == 0, "R4 stale high not accepted", tmo_cnt, 1);
      chk(strobes == 1, "R4 no second strobe on stale high", strobes, 1);
      pll_mode = 0; pll_done = 1'b1; ack = 1'b1;
      tick(4);
   endtask

   task automatic t_busy_ignore();
      clear_mon();
      pll_mode = 0; pll_dly = 6; exp_up = 1'b1; exp_sel = 4'd2;
      issue(3, 1'b1, 4'd2, 40);
      tick(5);
      issue(5, 1'b0, 4'd5, 40);
      wait_end();
      chk(strobes == 3, "R8 busy request ignored, count", strobes, 3);
      chk(hold_err == 0 && setup_err == 0, "R8 busy request ignored, outputs", hold_err + setup_err, 0);
      clear_mon();
      tick(20);
      chk(strobes == 0 && busy_seen == 0, "R8 no later activity", strobes + busy_seen, 0);
   endtask

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(3);
      t_reset();
      t_run(3, 1'b1, 4'd0, 4);
      t_run(2, 1'b0, 4'd11, 7);
      t_run(1, 1'b1, 4'd10, 20);
      t_zero();
      t_badsel(4'd12);
      t_badsel(4'd15);
      t_timeout();
      t_stale();
      t_busy_ignore();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule